// File: doc/BRIEF.md
# Serial Flash Command and Power Controller

This block is the control core of a small serial flash slave. A host frames each instruction with an active-low chip select and clocks it in over an SPI mode 0 link. The block decodes the instruction, keeps a write-enable latch and a busy flag, and runs program and erase cycles on an internal byte array. The host reads the array and the status byte back over the same link. All SPI pins are sampled in the system clock domain, so the serial clock must run at a quarter of the system clock or slower.

Programming can only clear bits. A page program first collects its data in a page-wide buffer with one valid bit per column. When chip select rises, a walker visits every column of the page and writes the AND of the stored byte and the buffered byte. An erase uses the same walker and writes 0xFF over a page or a sector. A programmable wait follows every walk and stands in for the cell timing. The busy flag can be polled for the whole cycle.

The block reports its power mode on a two-bit output. It is active while selected or while a cycle runs, and in standby otherwise. A deep power-down instruction puts it in a mode that only the wake instruction leaves.

Top module: `spi_flash_ctrl`

## Requirements
- R1: Bits are sampled on rising SCK, MSB first, and opcodes are 8 bits. Writing instructions (0x06, 0x04, 0x02, 0xDB, 0xD8, 0xB9, 0xAB) take effect at the chip-select rising edge, and only when a whole number of bytes was sent. A frame that ends with a partial byte changes nothing.
- R2: 0x06 sets the write-enable latch and 0x04 clears it. Status read 0x05 returns the status byte after the opcode, repeated for as long as chip select stays low: bit0 = busy (WIP), bit1 = write-enable latch, bits 7:2 = 0.
- R3: Read 0x03 is followed by a 24-bit address, MSB first. It then returns array bytes from that address onward, one per byte slot. The address wraps at the end of the array.
- R4: Page program 0x02 is followed by a 24-bit address and data bytes. Each addressed byte becomes the old byte ANDed with the new byte, so bits only go from 1 to 0.
- R5: Program data fills the page from the column given by the low address byte. The column wraps inside the page, so with more than PAGE_BYTES data bytes only the last PAGE_BYTES are kept. No other page changes.
- R6: 0xDB with an address sets every byte of that page to 0xFF. 0xD8 with an address does the same for the whole sector (PAGES_PER_SECTOR pages). Bytes outside the target keep their values.
- R7: Program and erase start only while the write-enable latch is set. The latch stays set for the whole cycle and clears when the cycle ends.
- R8: WIP reads 1 from the chip-select rising edge that starts a cycle until the cycle ends, then reads 0.
- R9: While WIP is 1, every instruction except status read is ignored, and read returns 0x00 bytes.
- R10: power_state is 2'b01 (active) while chip select is low or a cycle runs, 2'b00 (standby) otherwise, and 2'b10 in deep power-down.
- R11: 0xB9 enters deep power-down. In that mode every instruction except 0xAB is ignored, including program and erase, and status read returns 0x00. 0xAB returns to standby with the latch unchanged.
- R12: While rst_n is low, no instruction is accepted. Reset clears the latch, the busy flag and deep power-down, and leaves array contents not under a running cycle intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SPI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | Active-low chip select, frames one instruction |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, changes on falling SCK |
| power_state | output | 2 | 00 standby, 01 active, 10 deep power-down |

## Verification
Two functions of this block can fall in the same cycle. The first is status polling, which is served live from the shift path. The second is the internal program or erase walk, which owns the busy flag and the write-enable latch. The bench starts cycles and polls status right away. It also sends read, sleep and disable instructions while the walk is still running, and judges them by what later status and data reads show: WIP seen as 1, then WIP and the latch dropping together, reads returning zero, and a sleep sent during a cycle leaving the latch usable afterwards.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_PERASE = 8'hDB;
  localparam logic [7:0] OP_SERASE = 8'hD8;
  localparam logic [7:0] OP_SLEEP  = 8'hB9;
  localparam logic [7:0] OP_WAKE   = 8'hAB;

  typedef enum logic [1:0] {
    PWR_STANDBY = 2'b00,
    PWR_ACTIVE  = 2'b01,
    PWR_DEEP    = 2'b10
  } pwr_e;

  typedef enum logic [1:0] {
    JOB_NONE   = 2'd0,
    JOB_PROG   = 2'd1,
    JOB_PERASE = 2'd2,
    JOB_SERASE = 2'd3
  } job_e;

  // programming may only clear bits
  function automatic logic [7:0] merge_prog(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic [7:0] status_byte(input logic wip, input logic wel);
    return {6'b000000, wel, wip};
  endfunction

endpackage

// File: rtl/spi_flash_port.sv
module spi_flash_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [7:0] tx_next,
  output logic       miso,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       cs_rise,
  output logic       aligned
);

  logic       sck_q;
  logic       cs_q;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic       sck_rise;
  logic       sck_fall;

  assign sck_rise  = !cs_n && sck && !sck_q;
  assign sck_fall  = !cs_n && !sck && sck_q;
  assign byte_done = sck_rise && (bit_cnt == 3'd7);
  assign rx_byte   = {rx_sh, mosi};
  assign cs_rise   = cs_n && !cs_q;
  assign aligned   = (bit_cnt == 3'd0);
  assign miso      = tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      bit_cnt <= 3'd0;
      rx_sh   <= 7'd0;
      tx_sh   <= 8'd0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        bit_cnt <= 3'd0;
        tx_sh   <= 8'd0;
      end else begin
        if (sck_rise) begin
          rx_sh   <= {rx_sh[5:0], mosi};
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (sck_fall) begin
          // a new byte starts after each byte boundary
          if (bit_cnt == 3'd0) tx_sh <= tx_next;
          else                 tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/spi_flash_engine.sv
module spi_flash_engine
  import spi_flash_pkg::*;
#(
  parameter int PAGE_BYTES       = 256,
  parameter int PAGES_PER_SECTOR = 2,
  parameter int SECTORS          = 2,
  parameter int PROG_WAIT        = 24,
  parameter int ERASE_WAIT       = 40
) (
  input  logic                                               clk,
  input  logic                                               rst_n,
  input  logic                                               start,
  input  job_e                                               job,
  input  logic [$clog2(PAGE_BYTES*PAGES_PER_SECTOR*SECTORS)-1:0] addr,
  input  logic                                               buf_clr,
  input  logic                                               buf_we,
  input  logic [$clog2(PAGE_BYTES)-1:0]                      buf_col,
  input  logic [7:0]                                         buf_data,
  input  logic [$clog2(PAGE_BYTES*PAGES_PER_SECTOR*SECTORS)-1:0] rd_addr,
  output logic [7:0]                                         rd_data,
  output logic                                               busy,
  output logic                                               done,
  output logic                                               arr_we
);

  localparam int SECTOR_BYTES = PAGE_BYTES * PAGES_PER_SECTOR;
  localparam int ARRAY_BYTES  = SECTOR_BYTES * SECTORS;
  localparam int AW           = $clog2(ARRAY_BYTES);
  localparam int CW           = $clog2(PAGE_BYTES);
  localparam int WW           = $clog2(SECTOR_BYTES) + 1;
  localparam int MAXW         = (PROG_WAIT > ERASE_WAIT) ? PROG_WAIT : ERASE_WAIT;
  localparam int TW           = $clog2(MAXW + 1) + 1;

  logic [7:0]            mem  [ARRAY_BYTES];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvalid;

  job_e          job_q;
  logic [AW-1:0] base_q;
  logic [WW-1:0] idx;
  logic          walking;
  logic [TW-1:0] wait_cnt;
  logic [AW-1:0] w_addr;
  logic [CW-1:0] col;
  logic [7:0]    wr_data;

  function automatic logic [WW-1:0] last_idx(input job_e j);
    return (j == JOB_SERASE) ? WW'(SECTOR_BYTES - 1) : WW'(PAGE_BYTES - 1);
  endfunction

  function automatic logic [AW-1:0] align_base(input logic [AW-1:0] a, input job_e j);
    if (j == JOB_SERASE) return a & ~AW'(SECTOR_BYTES - 1);
    return a & ~AW'(PAGE_BYTES - 1);
  endfunction

  function automatic logic [TW-1:0] wait_for(input job_e j);
    return (j == JOB_PROG) ? TW'(PROG_WAIT) : TW'(ERASE_WAIT);
  endfunction

  assign w_addr  = base_q + AW'(idx);
  assign col     = idx[CW-1:0];
  assign arr_we  = walking;
  assign done    = busy && !walking && (wait_cnt == '0);
  assign rd_data = mem[rd_addr];

  always_comb begin
    if (job_q == JOB_PROG)
      wr_data = pvalid[col] ? merge_prog(mem[w_addr], pbuf[col]) : mem[w_addr];
    else
      wr_data = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (arr_we) mem[w_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_col] <= buf_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pvalid <= '0;
    else if (buf_clr) pvalid <= '0;
    else if (buf_we)  pvalid[buf_col] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      walking  <= 1'b0;
      idx      <= '0;
      wait_cnt <= '0;
      job_q    <= JOB_NONE;
      base_q   <= '0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      walking  <= 1'b1;
      idx      <= '0;
      job_q    <= job;
      base_q   <= align_base(addr, job);
      wait_cnt <= wait_for(job);
    end else if (walking) begin
      if (idx == last_idx(job_q)) walking <= 1'b0;
      idx <= idx + 1'b1;
    end else if (busy) begin
      if (wait_cnt == '0) busy <= 1'b0;
      else                wait_cnt <= wait_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl
  import spi_flash_pkg::*;
#(
  parameter int PAGE_BYTES       = 256,
  parameter int PAGES_PER_SECTOR = 2,
  parameter int SECTORS          = 2,
  parameter int PROG_WAIT        = 24,
  parameter int ERASE_WAIT       = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  output logic [1:0] power_state
);

  localparam int ARRAY_BYTES = PAGE_BYTES * PAGES_PER_SECTOR * SECTORS;
  localparam int AW          = $clog2(ARRAY_BYTES);
  localparam int CW          = $clog2(PAGE_BYTES);

  logic          byte_done;
  logic [7:0]    rx_byte;
  logic          cs_rise;
  logic          aligned;
  logic [7:0]    tx_next;

  logic [7:0]    opcode;
  logic [AW-1:0] addr_sh;
  logic [2:0]    idx_cnt;
  logic          pp_any;
  logic [CW-1:0] col;
  logic [AW-1:0] rd_ptr;
  logic          wel;
  logic          dp;

  logic          eng_busy;
  logic          eng_done;
  logic          arr_we;
  logic [7:0]    rd_data;

  // named internal events
  logic          exec;
  logic          live_exec;
  logic          wake;
  logic          start_any;
  logic          frame_live;
  logic          buf_clr;
  logic          buf_we;
  job_e          job_sel;

  spi_flash_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck       (sck),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .tx_next   (tx_next),
    .miso      (miso),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .cs_rise   (cs_rise),
    .aligned   (aligned)
  );

  spi_flash_engine #(
    .PAGE_BYTES       (PAGE_BYTES),
    .PAGES_PER_SECTOR (PAGES_PER_SECTOR),
    .SECTORS          (SECTORS),
    .PROG_WAIT        (PROG_WAIT),
    .ERASE_WAIT       (ERASE_WAIT)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_any),
    .job      (job_sel),
    .addr     (addr_sh),
    .buf_clr  (buf_clr),
    .buf_we   (buf_we),
    .buf_col  (col),
    .buf_data (rx_byte),
    .rd_addr  (rd_ptr),
    .rd_data  (rd_data),
    .busy     (eng_busy),
    .done     (eng_done),
    .arr_we   (arr_we)
  );

  assign frame_live = !dp && !eng_busy;
  assign buf_clr    = byte_done && (idx_cnt == 3'd0) && (rx_byte == OP_PROG) && frame_live;
  assign buf_we     = byte_done && (idx_cnt == 3'd4) && (opcode == OP_PROG) && frame_live;

  assign exec      = cs_rise && aligned && (idx_cnt != 3'd0);
  assign wake      = exec && dp && (opcode == OP_WAKE);
  assign live_exec = exec && frame_live;

  always_comb begin
    job_sel = JOB_NONE;
    if (opcode == OP_PROG)        job_sel = JOB_PROG;
    else if (opcode == OP_PERASE) job_sel = JOB_PERASE;
    else if (opcode == OP_SERASE) job_sel = JOB_SERASE;
  end

  assign start_any = live_exec && wel &&
                     (((job_sel == JOB_PROG) && pp_any) ||
                      (((job_sel == JOB_PERASE) || (job_sel == JOB_SERASE)) && (idx_cnt == 3'd4)));

  always_comb begin
    tx_next = 8'h00;
    if (!dp) begin
      if ((opcode == OP_RDSR) && (idx_cnt != 3'd0))
        tx_next = status_byte(eng_busy, wel);
      else if ((opcode == OP_READ) && (idx_cnt == 3'd4) && !eng_busy)
        tx_next = rd_data;
    end
  end

  // frame parsing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode  <= 8'h00;
      addr_sh <= '0;
      idx_cnt <= 3'd0;
      pp_any  <= 1'b0;
      col     <= '0;
      rd_ptr  <= '0;
    end else if (cs_n) begin
      idx_cnt <= 3'd0;
      pp_any  <= 1'b0;
    end else if (byte_done) begin
      if (idx_cnt == 3'd0) opcode <= rx_byte;
      if ((idx_cnt != 3'd0) && (idx_cnt != 3'd4)) addr_sh <= AW'({addr_sh, rx_byte});
      if (idx_cnt == 3'd3) begin
        col    <= CW'({addr_sh, rx_byte});
        rd_ptr <= AW'({addr_sh, rx_byte});
      end
      if (idx_cnt == 3'd4) begin
        if (opcode == OP_PROG) begin
          col    <= col + 1'b1;
          pp_any <= 1'b1;
        end
        if (opcode == OP_READ) rd_ptr <= rd_ptr + 1'b1;
      end
      if (idx_cnt != 3'd4) idx_cnt <= idx_cnt + 3'd1;
    end
  end

  // write-enable latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wel <= 1'b0;
    else if (eng_done) wel <= 1'b0;
    else if (live_exec) begin
      if (opcode == OP_WREN)      wel <= 1'b1;
      else if (opcode == OP_WRDI) wel <= 1'b0;
    end
  end

  // deep power-down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 dp <= 1'b0;
    else if (wake)                              dp <= 1'b0;
    else if (live_exec && (opcode == OP_SLEEP)) dp <= 1'b1;
  end

  always_comb begin
    if (dp)                     power_state = PWR_DEEP;
    else if (!cs_n || eng_busy) power_state = PWR_ACTIVE;
    else                        power_state = PWR_STANDBY;
  end

endmodule

// File: rtl/spi_flash_ctrl_chk.sv
module spi_flash_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic start_any,
  input logic wel,
  input logic busy,
  input logic dp,
  input logic arr_we
);

  // latch held for the whole cycle
  assert_busy_keeps_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wel);

  // latch gone once the cycle ends
  assert_wel_drops_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  // an accepted start shows as WIP on the next cycle
  assert_start_raises_wip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_any |=> busy);

  // sleep is only entered from idle
  assert_sleep_only_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp) |-> !busy);

  // no array write in deep power-down
  assert_no_write_asleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dp |-> !arr_we);

  // nothing starts while asleep
  assert_no_start_asleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dp |=> !busy);

endmodule

bind spi_flash_ctrl spi_flash_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_any (start_any),
  .wel       (wel),
  .busy      (eng_busy),
  .dp        (dp),
  .arr_we    (arr_we)
);

// File: tb/spi_flash_ctrl_tb_top.sv
module spi_flash_ctrl_tb_top;

  localparam int PB = 256;
  localparam int SB = 512;
  localparam int AB = 1024;

  logic       clk;
  logic       rst_n;
  logic       sck;
  logic       cs_n;
  logic       mosi;
  logic       miso;
  logic [1:0] power_state;

  logic [7:0] txb  [0:299];
  logic [7:0] rxb  [0:299];
  logic [7:0] pdat [0:299];
  logic [7:0] bm   [0:AB-1];
  int nvec;
  int nfail;
  bit finished;

  spi_flash_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck         (sck),
    .cs_n        (cs_n),
    .mosi        (mosi),
    .miso        (miso),
    .power_state (power_state)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input int nb, input int xbits);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      logic [7:0] r;
      r = 8'h00;
      for (int k = 7; k >= 0; k--) begin
        mosi = txb[b][k];
        repeat (2) @(negedge clk);
        r[k] = miso;
        sck = 1'b1;
        repeat (2) @(negedge clk);
        sck = 1'b0;
      end
      rxb[b] = r;
    end
    for (int k = 0; k < xbits; k++) begin
      mosi = 1'b0;
      repeat (2) @(negedge clk);
      sck = 1'b1;
      repeat (2) @(negedge clk);
      sck = 1'b0;
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    txb[0] = op;
    frame(1, 0);
  endtask

  task automatic cmd_addr(input logic [7:0] op, input int addr);
    txb[0] = op;
    txb[1] = 8'h00;
    txb[2] = 8'((addr >> 8) & 255);
    txb[3] = 8'(addr & 255);
  endtask

  task automatic rdsr(output logic [7:0] s);
    txb[0] = 8'h05;
    txb[1] = 8'h00;
    frame(2, 0);
    s = rxb[1];
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] s;
    int polls;
    polls = 0;
    rdsr(s);
    while (s[0] && polls < 200) begin
      rdsr(s);
      polls++;
    end
    chk(req, {31'd0, s[0]}, 32'd0);
  endtask

  task automatic compare_range(input int addr, input int n, input string req);
    cmd_addr(8'h03, addr);
    for (int i = 0; i < n; i++) txb[4+i] = 8'h00;
    frame(4 + n, 0);
    for (int i = 0; i < n; i++)
      chk(req, {24'd0, rxb[4+i]}, {24'd0, bm[(addr + i) % AB]});
  endtask

  // page program through the link; model follows the requirement text
  task automatic do_prog(input int addr, input int n, input bit with_wren, input string req);
    logic [7:0] nb [0:PB-1];
    bit         nv [0:PB-1];
    int page;
    int c0;
    logic [7:0] s;
    if (with_wren) cmd1(8'h06);
    cmd_addr(8'h02, addr);
    for (int i = 0; i < n; i++) txb[4+i] = pdat[i];
    frame(4 + n, 0);
    rdsr(s);
    chk(req, {31'd0, s[0]}, {31'd0, with_wren});
    wait_idle(req);
    page = addr - (addr % PB);
    c0 = addr % PB;
    for (int c = 0; c < PB; c++) nv[c] = 1'b0;
    for (int i = 0; i < n; i++) begin
      nb[(c0 + i) % PB] = pdat[i];
      nv[(c0 + i) % PB] = 1'b1;
    end
    if (with_wren)
      for (int c = 0; c < PB; c++)
        if (nv[c]) bm[page + c] = bm[page + c] & nb[c];
  endtask

  task automatic do_erase(input logic [7:0] op, input int addr, input string req);
    logic [7:0] s;
    int base;
    int len;
    cmd1(8'h06);
    cmd_addr(op, addr);
    frame(4, 0);
    chk("R10 active while cycle runs", {30'd0, power_state}, 32'd1);
    rdsr(s);
    chk("R8 WIP set after start", {24'd0, s}, 32'h03);
    wait_idle(req);
    rdsr(s);
    chk("R7 latch cleared at cycle end", {24'd0, s}, 32'h00);
    len  = (op == 8'hD8) ? SB : PB;
    base = addr - (addr % len);
    for (int i = 0; i < len; i++) bm[base + i] = 8'hFF;
  endtask

  initial begin
    finished = 1'b0;
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    int page;
    int c0;
    int n;
    nvec  = 0;
    nfail = 0;
    rst_n = 1'b0;
    sck   = 1'b0;
    cs_n  = 1'b1;
    mosi  = 1'b0;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    chk("R10 standby after reset", {30'd0, power_state}, 32'd0);
    rdsr(s);
    chk("R2 status after reset", {24'd0, s}, 32'h00);
    cmd1(8'h06);
    rdsr(s);
    chk("R2 latch set by 0x06", {24'd0, s}, 32'h02);
    cmd1(8'h04);
    rdsr(s);
    chk("R2 latch cleared by 0x04", {24'd0, s}, 32'h00);

    // clean array, R6 sector erase
    do_erase(8'hD8, 0, "R6 sector 0 erase");
    do_erase(8'hD8, SB + 5, "R6 sector 1 erase");
    compare_range(0, 8, "R6 erased to FF");
    compare_range(AB - 4, 8, "R3 read wraps at array end");

    // R1 partial byte
    txb[0] = 8'h06;
    frame(1, 3);
    rdsr(s);
    chk("R1 partial byte ignored", {24'd0, s}, 32'h00);

    // R7 program without the latch
    for (int i = 0; i < 8; i++) pdat[i] = 8'h00;
    do_prog(0, 8, 1'b0, "R7 no latch no cycle");
    compare_range(0, 8, "R7 program without latch");

    // R4 AND merge
    pdat[0] = 8'hF0;
    do_prog(16, 1, 1'b1, "R4 first program");
    pdat[0] = 8'h3C;
    do_prog(16, 1, 1'b1, "R4 second program");
    chk("R4 model value", {24'd0, bm[16]}, 32'h30);
    compare_range(16, 1, "R4 bits only clear");

    // random programs in pages 0, 1, 3
    for (int it = 0; it < 6; it++) begin
      page = $urandom_range(0, 2);
      if (page == 2) page = 3;
      c0 = $urandom_range(0, PB - 1);
      n  = $urandom_range(1, 40);
      for (int i = 0; i < n; i++) pdat[i] = 8'($urandom);
      do_prog(page * PB + c0, n, 1'b1, "R4 random program");
      if (c0 + n > PB) begin
        compare_range(page * PB + c0, PB - c0, "R5 random tail");
        compare_range(page * PB, c0 + n - PB, "R5 random wrapped head");
      end else begin
        compare_range(page * PB + c0, n, "R4 random readback");
      end
    end

    // R6 page erase leaves neighbour alone, then R5 long wrap
    pdat[0] = 8'h00;
    do_prog(2 * PB + 7, 1, 1'b1, "R6 dirty page 2");
    do_erase(8'hDB, 2 * PB + 77, "R6 page erase");
    compare_range(2 * PB, 8, "R6 page erased");
    compare_range(3 * PB, 16, "R6 neighbour page kept");
    for (int i = 0; i < 260; i++) pdat[i] = 8'($urandom);
    do_prog(2 * PB + 250, 260, 1'b1, "R5 long program");
    compare_range(2 * PB, PB, "R5 wrap keeps last page of bytes");
    compare_range(3 * PB, 4, "R5 next page untouched");

    // R9 instructions during a cycle
    cmd1(8'h06);
    cmd_addr(8'hDB, PB);
    frame(4, 0);
    cmd_addr(8'h03, 16);
    txb[4] = 8'h00;
    frame(5, 0);
    chk("R9 read during cycle gives zero", {24'd0, rxb[4]}, 32'h00);
    cmd1(8'hB9);
    rdsr(s);
    chk("R9 status during cycle", {24'd0, s}, 32'h03);
    wait_idle("R9 cycle ends");
    for (int i = 0; i < PB; i++) bm[PB + i] = 8'hFF;
    chk("R9 sleep during cycle ignored", {30'd0, power_state}, 32'd0);
    cmd1(8'h06);
    rdsr(s);
    chk("R9 latch usable after cycle", {24'd0, s}, 32'h02);
    cmd1(8'h04);
    compare_range(PB, 8, "R6 page 1 erased");

    // R6 sector erase keeps other sector
    do_erase(8'hD8, SB, "R6 sector 1 again");
    compare_range(2 * PB, 16, "R6 sector 1 FF");
    compare_range(0, 32, "R6 sector 0 kept");

    // R10 selection alone makes it active
    @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 active while selected", {30'd0, power_state}, 32'd1);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 standby when deselected", {30'd0, power_state}, 32'd0);

    // R11 deep power-down
    cmd1(8'h06);
    cmd1(8'hB9);
    chk("R11 deep mode entered", {30'd0, power_state}, 32'd2);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 stays deep while selected", {30'd0, power_state}, 32'd2);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    rdsr(s);
    chk("R11 status ignored when asleep", {24'd0, s}, 32'h00);
    cmd_addr(8'hDB, 0);
    frame(4, 0);
    cmd1(8'h04);
    chk("R11 erase ignored, still asleep", {30'd0, power_state}, 32'd2);
    cmd1(8'hAB);
    chk("R11 wake to standby", {30'd0, power_state}, 32'd0);
    rdsr(s);
    chk("R11 latch unchanged, no cycle", {24'd0, s}, 32'h02);
    compare_range(0, 16, "R11 data kept across sleep");
    cmd1(8'h04);

    // R12 reset
    cmd1(8'h06);
    cmd_addr(8'h02, 3 * PB);
    txb[4] = 8'h00;
    frame(5, 0);
    rst_n = 1'b0;
    txb[0] = 8'h06;
    frame(1, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 standby after reset", {30'd0, power_state}, 32'd0);
    rdsr(s);
    chk("R12 cycle and latch cleared", {24'd0, s}, 32'h00);
    cmd1(8'hB9);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 reset leaves deep mode", {30'd0, power_state}, 32'd0);
    cmd1(8'h06);
    rdsr(s);
    chk("R12 instructions accepted again", {24'd0, s}, 32'h02);
    compare_range(0, 64, "R12 array kept over reset");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule